// File: doc/BRIEF.md
# Three-Register Evaluation Stack Datapath

This block is the execute half of a compact stack-oriented processor core. It keeps a three-deep evaluation stack (top `A`, then `B`, then `C`), a workspace pointer and an instruction pointer, all 32 bits wide. A decoder upstream delivers one operation at a time as a 4-bit operation code plus a fully assembled 32-bit argument. The block pushes, pops, adds and subtracts on the stack, moves the pointers, and reads or writes local words relative to the workspace pointer through a single-word memory port.

Register-only operations finish in the cycle they are accepted. Memory operations hold the block in a wait state until the memory raises its acknowledge. Fast on-chip memory (addresses with bit 31 set) acknowledges within one cycle. External memory takes longer. The datapath does not decode the region. It waits for the acknowledge for as many cycles as the memory needs.

The controller has three states. `ST_IDLE` accepts operations. `ST_LOAD` waits for a read to complete. `ST_STORE` waits for a write to complete. The transitions are:
- `ST_IDLE`→`ST_LOAD` when a load-local is accepted.
- `ST_IDLE`→`ST_STORE` when a store-local is accepted.
- `ST_LOAD`→`ST_IDLE` and `ST_STORE`→`ST_IDLE` on `mem_ack`.
- Every other case holds the present state.

Top module: `stackdp_core`

## Requirements
- R1: After reset, `stk_a`, `stk_b` and `stk_c` are 0, `wptr` equals `WPTR_RESET` (0x80000100), `iptr` equals `IPTR_RESET` (0), `op_ready` is 1 and `mem_req` is 0.
- R2: An operation is accepted on a clock edge where `op_valid` and `op_ready` are both 1. Code 0 (load constant) takes one cycle and pushes `op_arg`: C takes B, B takes A, and A takes `op_arg`.
- R3: Code 1 (add constant) takes one cycle. A becomes A + `op_arg`, and B and C are unchanged.
- R4: Code 5 (add) sets A to B + A, and code 6 (subtract) sets A to B − A. In both cases B takes C and C keeps its value. Both take one cycle.
- R5: Code 7 (reverse) swaps A and B in one cycle, and C is unchanged.
- R6: Code 3 (load local) raises `mem_req` with `mem_we` = 0 at address `wptr` + 4·`op_arg`. It holds `op_ready` at 0 until `mem_ack`. On that edge it pushes `mem_rdata` as in R2.
- R7: Code 4 (store local) raises `mem_req` with `mem_we` = 1 at address `wptr` + 4·`op_arg`, with `mem_wdata` = A. On the `mem_ack` edge it pops: A takes B, B takes C, and C keeps its value.
- R8: While a request waits, `mem_addr`, `mem_we` and the request stay stable. Any acknowledge latency is accepted, whether 1 cycle for on-chip memory or 3 or more cycles for external memory.
- R9: Code 2 (jump) adds `op_arg` to `iptr` modulo 2^32 in one cycle, and the stack is unchanged.
- R10: Code 8 (adjust workspace) adds 4·`op_arg` to `wptr`. Code 9 (set workspace) copies A into `wptr` and pops as in R7. Both take one cycle.
- R11: The stack has no overflow or underflow detection. A fourth push discards the old C, and repeated pops leave C replicated.
- R12: Operation codes 10 to 15 change no state. An `op_valid` raised while `op_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_code | input | 4 | Operation code |
| op_arg | input | 32 | Assembled operand |
| op_ready | output | 1 | Block can accept an operation |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data (stack top) |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the access |
| stk_a | output | 32 | Stack top A |
| stk_b | output | 32 | Stack register B |
| stk_c | output | 32 | Stack register C |
| wptr | output | 32 | Workspace pointer |
| iptr | output | 32 | Instruction pointer |

## Verification
The bench targets the following corner cases:
- **Fourth push and pop after overflow.** A design that shifted C away, or cleared C on a pop, would leave the wrong value in C.
- **Word scaling of local offsets.** Byte offsets would show up as a wrong request address and a wrong value read back.
- **Subtract operand order.** Getting it wrong gives A − B instead of B − A.
- **Accesses at both latencies.** A design that completed on the first cycle would push stale data or let a store finish early.
- **Stray `op_valid` during a stall.** A design that accepted it would push an extra value.
- **Negative jump and workspace offsets.** These must wrap correctly.
- **Unused operation codes.** They must leave every register alone.

// File: rtl/stackdp_pkg.sv
package stackdp_pkg;

    typedef enum logic [3:0] {
        OP_LDC  = 4'd0,
        OP_ADC  = 4'd1,
        OP_JMP  = 4'd2,
        OP_LDL  = 4'd3,
        OP_STL  = 4'd4,
        OP_ADD  = 4'd5,
        OP_SUB  = 4'd6,
        OP_REV  = 4'd7,
        OP_AJW  = 4'd8,
        OP_SETW = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_STORE = 2'd2
    } state_e;

    typedef enum logic [2:0] {
        STK_HOLD   = 3'd0,
        STK_PUSH   = 3'd1,
        STK_POP    = 3'd2,
        STK_POPSET = 3'd3,
        STK_SET    = 3'd4,
        STK_SWAP   = 3'd5
    } stk_e;

    typedef enum logic [1:0] {
        WP_HOLD = 2'd0,
        WP_ADD  = 2'd1,
        WP_SETA = 2'd2
    } wp_e;

endpackage

// File: rtl/stackdp_stack.sv
module stackdp_stack
    import stackdp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_e          act,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] a,
    output logic [DW-1:0] b,
    output logic [DW-1:0] c
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a <= '0;
            b <= '0;
            c <= '0;
        end else begin
            unique case (act)
                STK_PUSH: begin
                    c <= b;
                    b <= a;
                    a <= din;
                end
                STK_POP: begin
                    a <= b;
                    b <= c;
                end
                STK_POPSET: begin
                    a <= din;
                    b <= c;
                end
                STK_SET: a <= din;
                STK_SWAP: begin
                    a <= b;
                    b <= a;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/stackdp_alu.sv
module stackdp_alu
    import stackdp_pkg::*;
#(
    parameter int DW  = 32,
    parameter int WSH = 2
) (
    input  logic [3:0]    code,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] arg,
    input  logic [DW-1:0] wbase,
    output logic [DW-1:0] result,
    output logic [DW-1:0] local_addr
);

    assign local_addr = wbase + (arg << WSH);

    always_comb begin
        case (op_e'(code))
            OP_ADC:  result = a + arg;
            OP_ADD:  result = b + a;
            OP_SUB:  result = b - a;
            default: result = arg;
        endcase
    end

endmodule

// File: rtl/stackdp_ctrl.sv
module stackdp_ctrl
    import stackdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [3:0] op_code,
    input  logic       mem_ack,
    output logic       op_ready,
    output logic       mem_req,
    output logic       mem_we,
    output logic       addr_load,
    output logic       take_mem,
    output logic       jump_en,
    output stk_e       stk_act,
    output wp_e        wp_act
);

    state_e state_q, state_d;
    logic   accept;

    assign accept = op_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && op_e'(op_code) == OP_LDL) state_d = ST_LOAD;
                if (accept && op_e'(op_code) == OP_STL) state_d = ST_STORE;
            end
            ST_LOAD:  if (mem_ack) state_d = ST_IDLE;
            ST_STORE: if (mem_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        op_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        addr_load = 1'b0;
        take_mem  = 1'b0;
        jump_en   = 1'b0;
        stk_act   = STK_HOLD;
        wp_act    = WP_HOLD;
        unique case (state_q)
            ST_IDLE: begin
                op_ready = 1'b1;
                if (op_valid) begin
                    case (op_e'(op_code))
                        OP_LDC:  stk_act = STK_PUSH;
                        OP_ADC:  stk_act = STK_SET;
                        OP_JMP:  jump_en = 1'b1;
                        OP_LDL:  addr_load = 1'b1;
                        OP_STL:  addr_load = 1'b1;
                        OP_ADD:  stk_act = STK_POPSET;
                        OP_SUB:  stk_act = STK_POPSET;
                        OP_REV:  stk_act = STK_SWAP;
                        OP_AJW:  wp_act = WP_ADD;
                        OP_SETW: begin
                            wp_act  = WP_SETA;
                            stk_act = STK_POP;
                        end
                        default: ;
                    endcase
                end
            end
            ST_LOAD: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    stk_act  = STK_PUSH;
                    take_mem = 1'b1;
                end
            end
            ST_STORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) stk_act = STK_POP;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stackdp_core.sv
module stackdp_core
    import stackdp_pkg::*;
#(
    parameter int          DW         = 32,
    parameter logic [31:0] WPTR_RESET = 32'h8000_0100,
    parameter logic [31:0] IPTR_RESET = 32'h0000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] op_arg,
    output logic          op_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic [DW-1:0] stk_a,
    output logic [DW-1:0] stk_b,
    output logic [DW-1:0] stk_c,
    output logic [DW-1:0] wptr,
    output logic [DW-1:0] iptr
);

    localparam int WSH = $clog2(DW / 8);

    logic          addr_load, take_mem, jump_en;
    stk_e          stk_act;
    wp_e           wp_act;
    logic [DW-1:0] alu_res, local_addr, stk_din, addr_q;

    stackdp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .mem_ack   (mem_ack),
        .op_ready  (op_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .addr_load (addr_load),
        .take_mem  (take_mem),
        .jump_en   (jump_en),
        .stk_act   (stk_act),
        .wp_act    (wp_act)
    );

    stackdp_alu #(.DW(DW), .WSH(WSH)) u_alu (
        .code       (op_code),
        .a          (stk_a),
        .b          (stk_b),
        .arg        (op_arg),
        .wbase      (wptr),
        .result     (alu_res),
        .local_addr (local_addr)
    );

    assign stk_din = take_mem ? mem_rdata : alu_res;

    stackdp_stack #(.DW(DW)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (stk_act),
        .din   (stk_din),
        .a     (stk_a),
        .b     (stk_b),
        .c     (stk_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wptr   <= DW'(WPTR_RESET);
            iptr   <= DW'(IPTR_RESET);
        end else begin
            if (addr_load) addr_q <= local_addr;
            if (jump_en)   iptr   <= iptr + op_arg;
            unique case (wp_act)
                WP_ADD:  wptr <= local_addr;
                WP_SETA: wptr <= stk_a;
                default: ;
            endcase
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = stk_a;

endmodule

// File: rtl/stackdp_checker.sv
module stackdp_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic [DW-1:0] op_arg,
    input logic          op_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic [DW-1:0] mem_addr,
    input logic          mem_ack,
    input logic [DW-1:0] stk_a,
    input logic [DW-1:0] stk_b,
    input logic [DW-1:0] stk_c,
    input logic [DW-1:0] wptr,
    input logic [DW-1:0] iptr
);

    p_ready_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_ready && mem_req));

    p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && op_valid && op_code == 4'd0) |=>
        (stk_a == $past(op_arg) && stk_b == $past(stk_a) && stk_c == $past(stk_b)));

    p_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && op_valid && op_code == 4'd5) |=>
        (stk_a == $past(stk_b) + $past(stk_a) && stk_b == $past(stk_c) && stk_c == $past(stk_c)));

    p_store_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=>
        (op_ready && stk_a == $past(stk_b) && stk_b == $past(stk_c) && stk_c == $past(stk_c)));

    p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && op_valid && op_code == 4'd2) |=>
        (iptr == $past(iptr) + $past(op_arg) && $stable(stk_a)));

    p_stall_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=>
        ($stable(stk_a) && $stable(stk_b) && $stable(stk_c) && $stable(wptr) && $stable(iptr)));

endmodule

bind stackdp_core stackdp_checker #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_arg   (op_arg),
    .op_ready (op_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .stk_a    (stk_a),
    .stk_b    (stk_b),
    .stk_c    (stk_c),
    .wptr     (wptr),
    .iptr     (iptr)
);

// File: tb/stackdp_core_tb.sv
module stackdp_core_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] op_arg = '0;
    logic        op_ready, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [31:0] stk_a, stk_b, stk_c, wptr, iptr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] ea = 0, eb = 0, ec = 0, ew = 32'h8000_0100, ei = 0;
    logic [31:0] em [logic [31:0]];
    logic [31:0] mem [logic [31:0]];
    logic [159:0] exp_q [$];
    string        tag_q [$];
    int           lat_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stackdp_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .op_arg    (op_arg),
        .op_ready  (op_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .stk_a     (stk_a),
        .stk_b     (stk_b),
        .stk_c     (stk_c),
        .wptr      (wptr),
        .iptr      (iptr)
    );

    // Memory: 1 cycle for bit 31 set (on-chip), 3 cycles otherwise (R8)
    always @(negedge clk) begin
        if (!mem_req || mem_ack) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (lat_cnt + 1 >= (mem_addr[31] ? 1 : 3)) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            if (mem_we) mem[mem_addr] = mem_wdata;
        end else begin
            lat_cnt <= lat_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0 && op_ready) begin
                logic [159:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({stk_a, stk_b, stk_c, wptr, iptr} == e, t, stk_a, e[159:128]);
                if ({stk_a, stk_b, stk_c, wptr, iptr} != e)
                    $display("  detail %s: got %h %h %h %h %h want %h %h %h %h %h", t,
                             stk_a, stk_b, stk_c, wptr, iptr,
                             e[159:128], e[127:96], e[95:64], e[63:32], e[31:0]);
            end
        end
    end

    task automatic issue(input logic [3:0] code, input logic [31:0] arg, input string tag, input bit noise);
        logic [31:0] addr;
        addr = ew + (arg << 2);
        @(negedge clk);
        op_code  = code;
        op_arg   = arg;
        op_valid = 1'b1;
        case (code)
            4'd0: begin ec = eb; eb = ea; ea = arg; end
            4'd1: ea = ea + arg;
            4'd2: ei = ei + arg;
            4'd3: begin ec = eb; eb = ea; ea = em.exists(addr) ? em[addr] : 32'h0; end
            4'd4: begin em[addr] = ea; ea = eb; eb = ec; end
            4'd5: begin ea = eb + ea; eb = ec; end
            4'd6: begin ea = eb - ea; eb = ec; end
            4'd7: begin logic [31:0] t; t = ea; ea = eb; eb = t; end
            4'd8: ew = ew + (arg << 2);
            4'd9: begin ew = ea; ea = eb; eb = ec; end
            default: ;
        endcase
        @(negedge clk);
        op_valid = 1'b0;
        if (code == 4'd3 || code == 4'd4) begin
            string r;
            r = (code == 4'd3) ? "R6" : "R7";
            chk(mem_req && !op_ready, {r, " request raised, stalled"}, {31'b0, mem_req}, 32'h1);
            chk(mem_addr == addr, {r, " word-scaled address"}, mem_addr, addr);
            chk(mem_we == (code == 4'd4), {r, " write enable"}, {31'b0, mem_we}, {31'b0, code == 4'd4});
            if (noise) begin
                op_code  = 4'd0;
                op_arg   = 32'd99;
                op_valid = 1'b1;
                @(negedge clk);
                op_valid = 1'b0;
            end
        end
        exp_q.push_back({ea, eb, ec, ew, ei});
        tag_q.push_back(tag);
        while (!op_ready) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stk_a == 0 && stk_b == 0 && stk_c == 0, "R1 stack cleared", stk_a, 32'h0);
        chk(wptr == 32'h8000_0100, "R1 wptr reset", wptr, 32'h8000_0100);
        chk(iptr == 32'h0, "R1 iptr reset", iptr, 32'h0);
        chk(op_ready && !mem_req, "R1 ready, no request", {31'b0, op_ready}, 32'h1);

        issue(4'd0, 32'd5,  "R2 load constant 5", 0);
        issue(4'd0, 32'd7,  "R2 load constant 7", 0);
        issue(4'd5, 32'd0,  "R4 add", 0);
        issue(4'd0, 32'd3,  "R2 load constant 3", 0);
        issue(4'd6, 32'd0,  "R4 subtract order B-A", 0);
        issue(4'd0, 32'd40, "R2 load constant 40", 0);
        issue(4'd7, 32'd0,  "R5 reverse", 0);
        issue(4'd1, 32'hFFFF_FFFE, "R3 add constant negative", 0);
        issue(4'd0, 32'd1,  "R11 push 1", 0);
        issue(4'd0, 32'd2,  "R11 push 2", 0);
        issue(4'd0, 32'd3,  "R11 push 3", 0);
        issue(4'd0, 32'd4,  "R11 fourth push drops C", 0);
        issue(4'd5, 32'd0,  "R11 pop keeps C", 0);
        issue(4'd5, 32'd0,  "R11 second pop replicates C", 0);
        issue(4'd2, 32'd16, "R9 jump forward", 0);
        issue(4'd2, 32'hFFFF_FFFC, "R9 jump backward", 0);
        issue(4'd4, 32'd2,  "R7 store local on-chip", 0);
        issue(4'd0, 32'hAB,  "R2 load constant AB", 0);
        issue(4'd3, 32'd2,  "R6 load local on-chip", 0);
        issue(4'd8, 32'hFFFF_FFFE, "R10 adjust workspace negative", 0);
        issue(4'd0, 32'h0000_2000, "R2 load external base", 0);
        issue(4'd9, 32'd0,  "R10 set workspace pops", 0);
        issue(4'd0, 32'h1234_5678, "R2 load constant data", 0);
        issue(4'd4, 32'd1,  "R8 store local external, R12 stray op ignored", 1);
        issue(4'd3, 32'd1,  "R8 load local external, R12 stray op ignored", 1);
        issue(4'd3, 32'd9,  "R6 load local unwritten word", 0);
        issue(4'd12, 32'd77, "R12 unused code 12", 0);
        issue(4'd15, 32'd5,  "R12 unused code 15", 0);

        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule